// File: doc/BRIEF.md
# Two-Level Rotating DMA Channel Priority Arbiter

This block chooses which of eight DMA channels is served next. The channels are arranged in two nested priority groups. The lower group holds channels 0 to 3. The upper group has four slots: the lower group taken as a whole, then channels 5, 6 and 7. Channel 4 is never a transfer channel. Its place in the upper group is filled by the lower group, so the lower group's channels outrank channels 5 to 7 whenever the upper group is in fixed order.

A channel asks for service through its hardware request line or its software request bit. Either source counts the same for arbitration. A set mask bit removes the channel from arbitration. Each group has its own mode bit that picks fixed or rotating order. The grant is formed combinationally in the same cycle from the requests and the stored rotation state. A service-complete pulse, carrying the number of the channel that was served, advances the rotation pointer of any group that is in rotating mode. In that mode the served entry drops to the lowest priority within its group.

Top module: `dma_prio_arbiter`

## Requirements
- R1: A channel takes part in arbitration exactly when (hw_req OR sw_req) is set for it and its mask bit is clear; a software request alone wins exactly as a hardware request would.
- R2: `grant` has at most one bit set. `grant_vld` is high exactly when some channel takes part in arbitration. With no such channel, `grant` is all zeros.
- R3: `grant[4]` is never set. Requests on channel 4 never produce a grant. A service pulse naming channel 4 leaves both rotation states unchanged.
- R4: With both mode bits low (fixed), the winner is the first participating channel in the order 0, 1, 2, 3, 5, 6, 7.
- R5: With `lo_rotate` high, a service pulse for channel c in 0..3 makes the lower-group order c+1, c+2, c+3, c (modulo 4). The upper order is unchanged.
- R6: With `hi_rotate` high, a service pulse makes the served upper slot the lowest. The slots in index order are the lower group (slot 0), channel 5 (slot 1), channel 6 (slot 2) and channel 7 (slot 3). A pulse for any channel 0..3 serves slot 0.
- R7: A group whose mode bit is low ignores its stored pointer and uses fixed order. Its pointer only moves on a service pulse taken while its mode bit is high. The two groups' pointers move independently.
- R8: After reset both pointers are at their top: channel 0 first in the lower group, and the lower-group slot first in the upper group.
- R9: The grant follows the inputs in the same cycle. Rotation state changes only at the clock edge that samples `done_vld` high. Mask bits do not alter the rotation state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | 8 | Hardware request line per channel |
| sw_req | input | 8 | Software request bit per channel |
| ch_mask | input | 8 | Per-channel mask, 1 excludes the channel |
| lo_rotate | input | 1 | Lower group (0..3): 0 fixed, 1 rotating |
| hi_rotate | input | 1 | Upper group (lower slot,5,6,7): 0 fixed, 1 rotating |
| done_vld | input | 1 | Service-complete pulse |
| done_ch | input | 3 | Channel number the pulse refers to |
| grant | output | 8 | One-hot grant per channel |
| grant_vld | output | 1 | A grant is present |

## Verification
The service-complete pulse and fresh arbitration can fall in the same cycle. The grant is then still formed from the old pointers, while the pointers move at the edge that ends the cycle. The random stimulus raises `done_vld` in about a third of the cycles and changes the requests, masks and both mode bits at the same moment. A reference model updates its pointers only after it has checked that cycle's grant. A grant seen before the edge must match the old order, and the first grant after the edge must match the new one.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    localparam int NCH      = 8;
    localparam int LO_N     = 4;
    localparam int HI_SLOTS = 4;
    localparam int CHW      = $clog2(NCH);
    localparam int LSW      = $clog2(LO_N);
    localparam int HSW      = $clog2(HI_SLOTS);

    typedef logic [CHW-1:0] ch_idx_t;

    typedef struct packed {
        logic    vld;
        ch_idx_t ch;
    } svc_t;

    function automatic logic in_lower(ch_idx_t ch);
        return int'(ch) < LO_N;
    endfunction

    function automatic logic [HSW-1:0] upper_slot(ch_idx_t ch);
        if (in_lower(ch)) return '0;
        return HSW'(int'(ch) - LO_N);
    endfunction

    function automatic logic [LSW-1:0] lower_slot(ch_idx_t ch);
        return LSW'(ch);
    endfunction
endpackage

// File: rtl/dma_req_qualify.sv
module dma_req_qualify #(
    parameter int N    = 8,
    parameter int HOLE = 4
) (
    input  logic [N-1:0] hw,
    input  logic [N-1:0] sw,
    input  logic [N-1:0] msk,
    output logic [N-1:0] eff
);
    for (genvar i = 0; i < N; i++) begin : g_q
        if (i == HOLE) begin : g_hole
            assign eff[i] = 1'b0;
        end else begin : g_live
            assign eff[i] = (hw[i] | sw[i]) & ~msk[i];
        end
    end

    always_comb begin
        assert_hole_silent_R3: assert (eff[HOLE] == 1'b0);
    end
endmodule

// File: rtl/dma_rot_group.sv
module dma_rot_group #(
    parameter int SLOTS = 4,
    localparam int IW   = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rotate,
    input  logic [SLOTS-1:0] req,
    input  logic             upd,
    input  logic [IW-1:0]    upd_slot,
    output logic [SLOTS-1:0] win,
    output logic             any
);
    logic [IW-1:0] ptr;
    logic [IW-1:0] base;
    logic [IW-1:0] nxt;
    logic [IW-1:0] idx;
    logic          found;

    assign base = rotate ? ptr : '0;
    assign nxt  = (int'(upd_slot) == SLOTS - 1) ? '0 : IW'(int'(upd_slot) + 1);

    always_comb begin
        win   = '0;
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < SLOTS; i++) begin
            idx = IW'((int'(base) + i) % SLOTS);
            if (!found && req[idx]) begin
                win[idx] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    assign any = found;

    always_ff @(posedge clk) begin
        if (rst)                ptr <= '0;
        else if (upd && rotate) ptr <= nxt;
    end

    assert_win_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win));
    assert_win_valid_R2: assert property (@(posedge clk) disable iff (rst)
        any == (req != '0));
    assert_win_in_req_R1: assert property (@(posedge clk) disable iff (rst)
        (win & ~req) == '0);
    assert_fixed_lowest_R7: assert property (@(posedge clk) disable iff (rst)
        (!rotate && req != '0) |-> (win == (req & (~req + 1'b1))));
    assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(upd && rotate) |=> $stable(ptr));
    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (upd && rotate) |=> (ptr == IW'((int'($past(upd_slot)) + 1) % SLOTS)));
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
    import dma_arb_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] hw_req,
    input  logic [NCH-1:0] sw_req,
    input  logic [NCH-1:0] ch_mask,
    input  logic           lo_rotate,
    input  logic           hi_rotate,
    input  logic           done_vld,
    input  logic [CHW-1:0] done_ch,
    output logic [NCH-1:0] grant,
    output logic           grant_vld
);
    logic [NCH-1:0]      eff;
    logic [LO_N-1:0]     lo_win;
    logic                lo_any;
    logic [HI_SLOTS-1:0] hi_req;
    logic [HI_SLOTS-1:0] hi_win;
    logic                hi_any;
    svc_t                svc;
    logic                lo_upd;
    logic                hi_upd;

    assign svc.vld = done_vld;
    assign svc.ch  = done_ch;
    assign lo_upd  = svc.vld && in_lower(svc.ch);
    assign hi_upd  = svc.vld && (int'(svc.ch) != LO_N);

    dma_req_qualify #(.N(NCH), .HOLE(LO_N)) u_qual (
        .hw (hw_req),
        .sw (sw_req),
        .msk(ch_mask),
        .eff(eff)
    );

    dma_rot_group #(.SLOTS(LO_N)) u_lo (
        .clk     (clk),
        .rst     (rst),
        .rotate  (lo_rotate),
        .req     (eff[LO_N-1:0]),
        .upd     (lo_upd),
        .upd_slot(lower_slot(svc.ch)),
        .win     (lo_win),
        .any     (lo_any)
    );

    assign hi_req = {eff[NCH-1:LO_N+1], lo_any};

    dma_rot_group #(.SLOTS(HI_SLOTS)) u_hi (
        .clk     (clk),
        .rst     (rst),
        .rotate  (hi_rotate),
        .req     (hi_req),
        .upd     (hi_upd),
        .upd_slot(upper_slot(svc.ch)),
        .win     (hi_win),
        .any     (hi_any)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_gnt
        if (i < LO_N) begin : g_lo
            assign grant[i] = hi_win[0] & lo_win[i];
        end else if (i == LO_N) begin : g_hole
            assign grant[i] = 1'b0;
        end else begin : g_hi
            assign grant[i] = hi_win[i-LO_N];
        end
    end

    assign grant_vld = hi_any;

    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    assert_grant_valid_R2: assert property (@(posedge clk) disable iff (rst)
        grant_vld == (eff != '0));
    assert_grant_eligible_R1: assert property (@(posedge clk) disable iff (rst)
        (grant & ~eff) == '0);
    assert_no_ch4_R3: assert property (@(posedge clk) disable iff (rst)
        !grant[LO_N]);
    assert_fixed_lower_first_R4: assert property (@(posedge clk) disable iff (rst)
        (!hi_rotate && eff[LO_N-1:0] != '0) |-> (grant[NCH-1:LO_N] == '0));
endmodule

// File: tb/tb_dma_prio_arbiter.sv
module tb_dma_prio_arbiter;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] hw_req, sw_req, ch_mask;
    logic       lo_rotate, hi_rotate, done_vld;
    logic [2:0] done_ch;
    logic [7:0] grant;
    logic       grant_vld;

    int tests = 0;
    int fails = 0;
    int m_lp = 0;
    int m_hp = 0;

    always #2 clk = ~clk;

    dma_prio_arbiter dut (
        .clk(clk), .rst(rst), .hw_req(hw_req), .sw_req(sw_req),
        .ch_mask(ch_mask), .lo_rotate(lo_rotate), .hi_rotate(hi_rotate),
        .done_vld(done_vld), .done_ch(done_ch),
        .grant(grant), .grant_vld(grant_vld)
    );

    function automatic logic [7:0] exp_grant();
        logic [7:0] e;
        logic [3:0] hs;
        e = (hw_req | sw_req) & ~ch_mask;
        e[4] = 1'b0;
        hs = {e[7:5], |e[3:0]};
        for (int i = 0; i < 4; i++) begin
            int s;
            s = ((hi_rotate ? m_hp : 0) + i) % 4;
            if (hs[s]) begin
                if (s != 0) return 8'(1) << (4 + s);
                for (int j = 0; j < 4; j++) begin
                    int c;
                    c = ((lo_rotate ? m_lp : 0) + j) % 4;
                    if (e[c]) return 8'(1) << c;
                end
            end
        end
        return 8'h00;
    endfunction

    task automatic check(input string tag);
        logic [7:0] ex;
        ex = exp_grant();
        tests++;
        if (grant !== ex || grant_vld !== (ex != 0)) begin
            fails++;
            $display("FAIL %s: grant=%b vld=%b expected grant=%b vld=%b",
                     tag, grant, grant_vld, ex, ex != 0);
        end
    endtask

    task automatic model_edge();
        if (done_vld) begin
            if (done_ch < 4) begin
                if (lo_rotate) m_lp = (int'(done_ch) + 1) % 4;
                if (hi_rotate) m_hp = 1;
            end else if (done_ch != 4) begin
                if (hi_rotate) m_hp = (int'(done_ch) - 3) % 4;
            end
        end
    endtask

    task automatic step(input string tag);
        #1 check(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        done_vld = 1'b0;
    endtask

    task automatic drive(input logic [7:0] h, input logic [7:0] s, input logic [7:0] m,
                         input logic lr, input logic hr, input logic dv, input logic [2:0] dc);
        hw_req = h; sw_req = s; ch_mask = m;
        lo_rotate = lr; hi_rotate = hr; done_vld = dv; done_ch = dc;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        drive(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step("R8 reset idle");
        drive(8'hFF, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 3'd0);
        step("R8 reset pointers top ch0");
        drive(8'hEE, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0);
        step("R4 fixed ch1 first");
        drive(8'hE0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0);
        step("R4 fixed ch5 first");
        drive(8'h00, 8'h40, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0);
        step("R1 software request ch6");
        drive(8'h03, 8'h00, 8'h01, 1'b0, 1'b0, 1'b0, 3'd0);
        step("R1 mask ch0");
        drive(8'h10, 8'h10, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0);
        step("R3 ch4 ignored");
        drive(8'h0F, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 3'd1);
        step("R9 same cycle old order");
        drive(8'h0F, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0);
        step("R5 lower rotated ch2");
        drive(8'h0F, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0);
        step("R7 lower fixed ignores pointer");
        drive(8'hE1, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 3'd4);
        step("R3 pulse ch4");
        drive(8'hE1, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0);
        step("R3 ch4 pulse no rotation");
        drive(8'hE1, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 3'd5);
        step("R6 serve ch5");
        drive(8'h61, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0);
        step("R6 ch6 outranks lower");
        drive(8'h61, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 3'd2);
        step("R6 lower service slot0");
        drive(8'h61, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b0, 3'd0);
        step("R2 all masked no grant");
        drive(8'h61, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0);
        step("R9 mask kept rotation ch5");
        for (int n = 0; n < 3000; n++) begin
            drive(8'($urandom), 8'($urandom) & 8'($urandom), 8'($urandom) & 8'($urandom),
                  1'($urandom), 1'($urandom), ($urandom % 3) == 0, 3'($urandom));
            step("R2 random");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule